// File: doc/BRIEF.md
# Warp Divergence Lane-Mask Stack

This block controls the set of lanes that commit results for one warp of a 32-lane SIMD engine. Every lane executes every instruction, and the active mask this block drives decides which lanes commit. Three commands move the mask:

- **Diverge** takes a per-lane predicate. It saves the current mask on an internal stack and narrows the active set to the lanes whose predicate is 1.
- **Flip** switches to the other side of the branch. The lanes of the saved mask that are not active now become active, and the active ones drop out.
- **Merge** sits at the reconvergence point. It pops the stack and restores the mask that was current before the matching diverge.

Nested branches stack up to a fixed depth. A diverge at full depth is refused and latches an overflow flag. A flip or a merge with nothing saved latches an underflow flag. Both flags are sticky until reset.

The controller takes at most one command per cycle. Its effect shows on the outputs after the next rising clock edge. Fetch, program-counter handling and the lane datapath belong to the surrounding pipeline.

Top module: `warp_mask_stack`

## Requirements
- R1: After reset, active_mask is all ones (0xFFFFFFFF), depth is 0, and both flags are 0.
- R2: A diverge (cmd_op=2'b01, cmd_valid=1) with depth below 8 makes active_mask equal to the previous active_mask AND cmd_pred, and increments depth, from the next clock edge.
- R3: A flip (cmd_op=2'b10) with depth above 0 makes active_mask equal to the saved top mask AND NOT the current active_mask; depth is unchanged.
- R4: A merge (cmd_op=2'b11) with depth above 0 restores active_mask to the value it had before the matching diverge, and decrements depth.
- R5: A lane that is inactive in the saved top mask never becomes active through a diverge or a flip, whatever the predicate.
- R6: A diverge at depth 8 sets the sticky overflow flag and leaves active_mask and depth unchanged.
- R7: A flip or merge at depth 0 sets the sticky underflow flag and leaves active_mask at all ones and depth at 0.
- R8: When cmd_valid is 0, or cmd_op is 2'b00, active_mask and depth hold, whatever cmd_pred is.
- R9: Nested merges restore the saved masks in reverse order of their diverges.
- R10: Once set, either flag stays set through all later commands until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 none, 01 diverge, 10 flip, 11 merge |
| cmd_pred | input | 32 | Per-lane branch predicate, used by diverge |
| active_mask | output | 32 | Lanes allowed to commit results |
| depth | output | 4 | Number of saved masks on the stack |
| ovf_flag | output | 1 | Sticky: a diverge was refused at full depth |
| udf_flag | output | 1 | Sticky: a flip or merge arrived with an empty stack |

## Verification
Every result of this block is due one rising edge after the command is presented: the mask, the depth and both flags all come from registers with no further stage. The bench drives each command on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, half a period after the edge that updated them. The idle checks drive a non-trivial predicate with no valid command, then sample at the same point, so a spurious update would already be visible there.

// File: rtl/wms_pkg.sv
package wms_pkg;
   // Command encoding seen on cmd_op
   typedef enum logic [1:0] {
      OP_IDLE    = 2'b00,
      OP_DIVERGE = 2'b01,
      OP_FLIP    = 2'b10,
      OP_MERGE   = 2'b11
   } wms_op_e;

   // One-hot strobes produced by the decoder
   typedef struct packed {
      logic push;
      logic flip;
      logic pop;
      logic ovf_evt;
      logic udf_evt;
   } wms_strobe_t;
endpackage

// File: rtl/wms_cmd_decode.sv
module wms_cmd_decode
   import wms_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
)(
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [CW-1:0] count,
   output wms_strobe_t   strobe
);
   wms_op_e op_e;
   logic    full;
   logic    empty;

   assign op_e  = wms_op_e'(cmd_op);
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_comb begin
      strobe = '0;
      if (cmd_valid) begin
         unique case (op_e)
            OP_DIVERGE: begin
               strobe.push    = !full;
               strobe.ovf_evt = full;
            end
            OP_FLIP: begin
               strobe.flip    = !empty;
               strobe.udf_evt = empty;
            end
            OP_MERGE: begin
               strobe.pop     = !empty;
               strobe.udf_evt = empty;
            end
            default: ;
         endcase
      end
   end

   // Only one stack action may result from a single command
   always_comb begin
      if (cmd_valid)
         AST_ONE_ACTION: assert ($onehot0({strobe.push, strobe.flip, strobe.pop,
                                           strobe.ovf_evt, strobe.udf_evt})); // R8
   end
endmodule

// File: rtl/wms_mask_lifo.sv
module wms_mask_lifo #(
   parameter int LANES       = 32,
   parameter int DEPTH       = 8,
   parameter bit CLEAR_SLOTS = 1'b1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [LANES-1:0] wr_mask,
   output logic [LANES-1:0] top_mask,
   output logic [CW-1:0]    count
);
   logic [LANES-1:0] slot_q [DEPTH];
   logic [IW-1:0]    top_idx;

   // Occupancy counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (push)
         count <= count + 1'b1;
      else if (pop)
         count <= count - 1'b1;
   end

   // One register per slot, written when the push lands on it
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (CLEAR_SLOTS) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[g] <= '1;
            else if (push && (count == CW'(g)))
               slot_q[g] <= wr_mask;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (push && (count == CW'(g)))
               slot_q[g] <= wr_mask;
         end
      end
   end

   assign top_idx  = IW'(count - 1'b1);
   assign top_mask = (count == '0) ? '1 : slot_q[top_idx];

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R6
   AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> count == $past(count) - 1'b1); // R4
   AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> count == $past(count) + 1'b1); // R2
endmodule

// File: rtl/wms_active_mask.sv
module wms_active_mask #(
   parameter int LANES = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             flip,
   input  logic             pop,
   input  logic [LANES-1:0] pred,
   input  logic [LANES-1:0] saved,
   output logic [LANES-1:0] mask_q
);
   // Per-lane next state: each lane only looks at its own bits
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic nxt;
      always_comb begin
         nxt = mask_q[l];
         if (push)
            nxt = mask_q[l] & pred[l];
         else if (flip)
            nxt = saved[l] & ~mask_q[l];
         else if (pop)
            nxt = saved[l];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[l] <= 1'b1;
         else
            mask_q[l] <= nxt;
      end
   end

   AST_PUSH_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> mask_q == $past(mask_q & pred)); // R2
   AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> mask_q == $past(saved)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(push || flip || pop) |=> $stable(mask_q)); // R8
endmodule

// File: rtl/warp_mask_stack.sv
module warp_mask_stack
   import wms_pkg::*;
#(
   parameter int LANES       = 32,
   parameter int DEPTH       = 8,
   parameter bit CLEAR_SLOTS = 1'b1,
   localparam int CW = $clog2(DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [LANES-1:0] cmd_pred,
   output logic [LANES-1:0] active_mask,
   output logic [CW-1:0]    depth,
   output logic             ovf_flag,
   output logic             udf_flag
);
   if (LANES < 1) begin : g_bad_lanes
      $error("warp_mask_stack: LANES must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("warp_mask_stack: DEPTH must be at least 1");
   end

   wms_strobe_t      strobe;
   logic [LANES-1:0] top_mask;

   wms_cmd_decode #(.DEPTH(DEPTH)) u_decode (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .count     (depth),
      .strobe    (strobe)
   );

   wms_mask_lifo #(
      .LANES       (LANES),
      .DEPTH       (DEPTH),
      .CLEAR_SLOTS (CLEAR_SLOTS)
   ) u_lifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (strobe.push),
      .pop      (strobe.pop),
      .wr_mask  (active_mask),
      .top_mask (top_mask),
      .count    (depth)
   );

   wms_active_mask #(.LANES(LANES)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (strobe.push),
      .flip   (strobe.flip),
      .pop    (strobe.pop),
      .pred   (cmd_pred),
      .saved  (top_mask),
      .mask_q (active_mask)
   );

   // Sticky error flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         udf_flag <= 1'b0;
      end else begin
         ovf_flag <= ovf_flag | strobe.ovf_evt;
         udf_flag <= udf_flag | strobe.udf_evt;
      end
   end

   AST_SUBSET_OF_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
      (active_mask & ~top_mask) == '0); // R5
   AST_EMPTY_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == '0) |-> (active_mask == '1)); // R7
   AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01 && depth == CW'(DEPTH))
         |=> ($stable(active_mask) && $stable(depth) && ovf_flag)); // R6
   AST_EMPTY_POP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op[1] && depth == '0) |=> udf_flag); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag); // R10
   AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      udf_flag |=> udf_flag); // R10
endmodule

// File: tb/warp_mask_stack_bench.sv
`timescale 1ns/1ps
module warp_mask_stack_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [31:0] cmd_pred = '0;
   logic [31:0] active_mask;
   logic [3:0]  depth;
   logic        ovf_flag;
   logic        udf_flag;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   warp_mask_stack u_warp_mask_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_pred    (cmd_pred),
      .active_mask (active_mask),
      .depth       (depth),
      .ovf_flag    (ovf_flag),
      .udf_flag    (udf_flag)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(string req, logic [31:0] m, int d, bit o, bit u);
      chk(req, "active_mask", active_mask, m);
      chk(req, "depth", 32'(depth), 32'(d));
      chk(req, "ovf_flag", 32'(ovf_flag), 32'(o));
      chk(req, "udf_flag", 32'(udf_flag), 32'(u));
   endtask

   // Present one command for one cycle; outputs valid at the returning negedge
   task automatic issue(logic v, logic [1:0] op, logic [31:0] p);
      @(negedge clk);
      cmd_valid = v;
      cmd_op    = op;
      cmd_pred  = p;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 2'b00;
      cmd_pred  = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk_state("R1", 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
   endtask

   task automatic t_diverge_flip_merge();
      issue(1'b1, 2'b01, 32'h0000_FFFF);
      chk_state("R2", 32'h0000_FFFF, 1, 1'b0, 1'b0);
      // predicate reaches outside the current mask: those lanes stay off
      issue(1'b1, 2'b01, 32'h00FF_00FF);
      chk_state("R5", 32'h0000_00FF, 2, 1'b0, 1'b0);
      issue(1'b1, 2'b10, 32'hFFFF_FFFF);
      chk_state("R3", 32'h0000_FF00, 2, 1'b0, 1'b0);
      issue(1'b1, 2'b10, 32'h0);
      chk_state("R3", 32'h0000_00FF, 2, 1'b0, 1'b0);
      issue(1'b1, 2'b11, 32'h0);
      chk_state("R4", 32'h0000_FFFF, 1, 1'b0, 1'b0);
      issue(1'b1, 2'b11, 32'h0);
      chk_state("R4", 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
   endtask

   task automatic t_idle();
      issue(1'b1, 2'b01, 32'hF0F0_F0F0);
      chk_state("R2", 32'hF0F0_F0F0, 1, 1'b0, 1'b0);
      issue(1'b0, 2'b01, 32'h0000_0001);
      chk_state("R8", 32'hF0F0_F0F0, 1, 1'b0, 1'b0);
      issue(1'b0, 2'b11, 32'h0);
      chk_state("R8", 32'hF0F0_F0F0, 1, 1'b0, 1'b0);
      issue(1'b1, 2'b00, 32'h0F0F_0F0F);
      chk_state("R8", 32'hF0F0_F0F0, 1, 1'b0, 1'b0);
      issue(1'b1, 2'b11, 32'h0);
      chk_state("R4", 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
   endtask

   task automatic t_overflow_nesting();
      for (int k = 0; k < 8; k++) begin
         issue(1'b1, 2'b01, ~(32'h1 << k));
         chk_state("R2", ~((32'h2 << k) - 32'h1), k + 1, 1'b0, 1'b0);
      end
      issue(1'b1, 2'b01, 32'h0);
      chk_state("R6", 32'hFFFF_FF00, 8, 1'b1, 1'b0);
      for (int j = 1; j <= 8; j++) begin
         issue(1'b1, 2'b11, 32'h0);
         chk_state("R9", ~((32'h1 << (8 - j)) - 32'h1), 8 - j, 1'b1, 1'b0);
      end
      chk("R10", "ovf_flag", 32'(ovf_flag), 32'd1);
   endtask

   task automatic t_underflow();
      do_reset();
      issue(1'b1, 2'b11, 32'h0);
      chk_state("R7", 32'hFFFF_FFFF, 0, 1'b0, 1'b1);
      do_reset();
      issue(1'b1, 2'b10, 32'h1234_5678);
      chk_state("R7", 32'hFFFF_FFFF, 0, 1'b0, 1'b1);
      issue(1'b1, 2'b01, 32'h0000_000F);
      chk_state("R10", 32'h0000_000F, 1, 1'b0, 1'b1);
      issue(1'b1, 2'b11, 32'h0);
      chk_state("R10", 32'hFFFF_FFFF, 0, 1'b0, 1'b1);
      do_reset();
      chk_state("R1", 32'hFFFF_FFFF, 0, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_diverge_flip_merge();
      t_idle();
      t_overflow_nesting();
      t_underflow();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule